// File: doc/BRIEF.md
# Oversampling Serial Receiver with Selectable Stop-Bit Policy

This block receives asynchronous 8-bit characters on one serial input line. An external prescaler supplies a clock-enable pulse at sixteen times the bit rate. The line first passes through a two-stage synchroniser. A low level seen on a tick arms a start search. The receiver confirms the start bit half a bit later, which also centres the sampling point. It then takes every later sample sixteen ticks after the one before. Timing is realigned on every start bit, so a rate mismatch between the two ends builds up over one character only.

Data bits arrive least significant first. The receiver then checks one or two stop bits. A policy input lets a receiver set for two stop bits accept a character as soon as the first stop bit is high. With that policy, gapless traffic from a one-stop-bit sender decodes cleanly. In every mode each character is either delivered clean or delivered with its framing flag set, so a character that is badly framed never vanishes without trace. The byte is held with a valid flag until the consumer acknowledges it. A byte that arrives while the previous one is still unread raises an overrun flag alongside the new byte.

Top module: `uart_rx_stoppol`

## Requirements
- R1: After reset, valid_o, frame_err_o and overrun_o are 0 and data_o is 0x00.
- R2: A low pulse on rxd_i that has ended before the mid-start-bit sample (8 ticks after the low level is first seen) is dropped as a glitch: no byte is delivered.
- R3: A frame is a low start bit, 8 data bits least significant first, then high stop bit(s). The byte appears on data_o with valid_o set in the cycle after the tick that samples the final stop bit, and data_o and frame_err_o change only on a delivery.
- R4: Characters decode correctly when the sender's bit period differs from the nominal period (16 ticks) by about 3 percent either way.
- R5: With two_stop_i = 0, a low stop bit delivers the byte with frame_err_o = 1. The receiver then does not arm a new start search until rxd_i has been seen high.
- R6: With two_stop_i = 1 and tolerant_i = 0, both stop bits must be high. A low second stop bit delivers the byte with frame_err_o = 1.
- R7: With two_stop_i = 1 and tolerant_i = 1, the byte is delivered after the first stop bit, so back-to-back one-stop-bit characters decode without errors.
- R8: valid_o stays 1 until ack_i is 1 in a cycle with no new delivery. valid_o is then 0 in the next cycle.
- R9: A delivery while valid_o = 1 and ack_i = 0 sets overrun_o = 1 with the new byte. A delivery in the same cycle as ack_i = 1, or while valid_o = 0, leaves overrun_o = 0.
- R10: frame_err_o and overrun_o describe the byte on data_o: every delivery rewrites both, and valid_o is 1 after every delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| two_stop_i | input | 1 | 1 selects two stop bits |
| tolerant_i | input | 1 | 1 accepts a character after the first stop bit |
| ack_i | input | 1 | Consumer has taken the held byte |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | Held byte not yet acknowledged |
| frame_err_o | output | 1 | Held byte had a low stop bit |
| overrun_o | output | 1 | Held byte replaced an unread one |

## Verification
An acknowledge from the consumer and the delivery of a new byte can land in the same cycle. Which one wins decides whether valid_o drops and whether overrun_o rises. The bench has a reference model of its own that predicts the cycle of the final stop sample. From that prediction it raises ack_i exactly on the delivery edge, and it also runs a case with no acknowledge at all. The bench then requires valid_o to stay set in both cases, with overrun_o clear in the first case and set in the second.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP1 = 3'd3,
    RX_STOP2 = 3'd4,
    RX_WAITH = 3'd5
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  // reset to idle-high so no false start after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
`timescale 1ns/1ps
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              two_stop_i,
  input  logic              tolerant_i,
  output logic              deliver_o,
  output logic              ferr_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shift_q, shift_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    bit_d     = bit_q;
    shift_d   = shift_q;
    deliver_o = 1'b0;
    ferr_o    = 1'b0;
    if (tick_i) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!line_i) begin
            state_d = RX_START;
            cnt_d   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_MID) begin
            cnt_d   = '0;
            bit_d   = '0;
            state_d = line_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d   = '0;
            shift_d = {line_i, shift_q[DATA_W-1:1]};
            if (bit_q == BIT_LAST) state_d = RX_STOP1;
            else                   bit_d   = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP1: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            if (!line_i) begin
              deliver_o = 1'b1;
              ferr_o    = 1'b1;
              state_d   = RX_WAITH;
            end else if (two_stop_i && !tolerant_i) begin
              state_d = RX_STOP2;
            end else begin
              deliver_o = 1'b1;
              state_d   = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP2: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d     = '0;
            deliver_o = 1'b1;
            ferr_o    = !line_i;
            state_d   = line_i ? RX_IDLE : RX_WAITH;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_WAITH: begin
          if (line_i) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
    end
  end

  assign byte_o = shift_q;
endmodule

// File: rtl/rx_hold.sv
`timescale 1ns/1ps
module rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deliver_i,
  input  logic              ferr_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (deliver_i) begin
      data_o  <= byte_i;
      ferr_o  <= ferr_i;
      ovr_o   <= valid_o & ~ack_i;  // same-cycle ack counts as read
      valid_o <= 1'b1;
    end else if (ack_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_stoppol.sv
`timescale 1ns/1ps
module uart_rx_stoppol #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              two_stop_i,
  input  logic              tolerant_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              frame_err_o,
  output logic              overrun_o
);
  logic              line_s;
  logic              rx_deliver;
  logic              rx_ferr;
  logic [DATA_W-1:0] rx_byte;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line_s),
    .two_stop_i(two_stop_i),
    .tolerant_i(tolerant_i),
    .deliver_o (rx_deliver),
    .ferr_o    (rx_ferr),
    .byte_o    (rx_byte)
  );

  rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .deliver_i(rx_deliver),
    .ferr_i   (rx_ferr),
    .byte_i   (rx_byte),
    .ack_i    (ack_i),
    .data_o   (data_o),
    .valid_o  (valid_o),
    .ferr_o   (frame_err_o),
    .ovr_o    (overrun_o)
  );
endmodule

// File: rtl/rx_checks.sv
`timescale 1ns/1ps
module rx_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              deliver_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              frame_err_o,
  input logic              overrun_o
);
  a_r8_valid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o);

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ack_i && !deliver_i |=> !valid_o);

  a_r9_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_i && valid_o && !ack_i |=> overrun_o);

  a_r9_no_false_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_i && (!valid_o || ack_i) |=> !overrun_o);

  a_r3_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deliver_i |=> $stable(data_o) && $stable(frame_err_o) && $stable(overrun_o));

  a_r10_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_i |=> valid_o);
endmodule

bind uart_rx_stoppol rx_checks #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .deliver_i  (rx_deliver),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .frame_err_o(frame_err_o),
  .overrun_o  (overrun_o)
);

// File: tb/uart_rx_stoppol_test.sv
`timescale 1ns/1ps
module uart_rx_stoppol_test;
  localparam int TDIV = 4;           // clocks per tick
  localparam int NOM  = 16 * TDIV;   // nominal bit period in clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic two_stop = 1'b0;
  logic tol = 1'b0;
  logic ack_man = 1'b0;
  logic ack_auto = 1'b0;
  logic ack_on_del = 1'b0;
  wire  ack = ack_man | ack_auto;
  logic [7:0] data_o;
  logic valid_o, frame_err_o, overrun_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  uart_rx_stoppol uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .two_stop_i(two_stop), .tolerant_i(tol), .ack_i(ack),
    .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o),
    .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
    end
  endtask

  // reference model: states 0 idle 1 start 2 data 3 stop1 4 stop2 5 wait-high
  int m_st, m_cnt, m_bit;
  logic [7:0] m_sh, m_data;
  logic m_s1, m_s2, m_valid, m_ferr, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_bit = 0; m_sh = 0; m_data = 0;
      m_s1 = 1; m_s2 = 1; m_valid = 0; m_ferr = 0; m_ovr = 0;
    end else begin
      logic del, fe;
      del = 0; fe = 0;
      if (tick) begin
        case (m_st)
          0: if (!m_s2) begin m_st = 1; m_cnt = 0; end
          1: if (m_cnt == 7) begin m_cnt = 0; m_bit = 0; m_st = m_s2 ? 0 : 2; end
             else m_cnt++;
          2: if (m_cnt == 15) begin
               m_cnt = 0; m_sh = {m_s2, m_sh[7:1]};
               if (m_bit == 7) m_st = 3; else m_bit++;
             end else m_cnt++;
          3: if (m_cnt == 15) begin
               m_cnt = 0;
               if (!m_s2) begin del = 1; fe = 1; m_st = 5; end
               else if (two_stop && !tol) m_st = 4;
               else begin del = 1; m_st = 0; end
             end else m_cnt++;
          4: if (m_cnt == 15) begin
               m_cnt = 0; del = 1; fe = !m_s2; m_st = m_s2 ? 0 : 5;
             end else m_cnt++;
          default: if (m_s2) m_st = 0;
        endcase
      end
      if (del) begin
        m_data = m_sh; m_ferr = fe; m_ovr = m_valid && !ack; m_valid = 1;
      end else if (ack) m_valid = 0;
      m_s2 = m_s1; m_s1 = rxd;
    end
  end

  function automatic bit predict_del(input bit tk);
    if (!tk || m_cnt != 15) return 0;
    if (m_st == 4) return 1;
    if (m_st == 3) return !m_s2 || !(two_stop && !tol);
    return 0;
  endfunction

  // tick and same-cycle ack, driven away from the active edge
  int ph = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ph = 0; tick = 0; ack_auto = 0;
    end else begin
      ph = (ph + 1) % TDIV;
      tick = (ph == 0);
      ack_auto = ack_on_del && predict_del(tick);
    end
  end

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({valid_o, frame_err_o, overrun_o, data_o} == {m_valid, m_ferr, m_ovr, m_data},
          tag, "model compare {valid,ferr,ovr,data}",
          {valid_o, frame_err_o, overrun_o, data_o}, {m_valid, m_ferr, m_ovr, m_data});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input int nstop, input int blen,
                      input bit stop_low);
    hold_line(1'b0, blen);
    for (int i = 0; i < 8; i++) hold_line(b[i], blen);
    for (int i = 0; i < nstop; i++) hold_line(!(stop_low && i == 0), blen);
  endtask

  task automatic do_ack();
    ack_man = 1'b1;
    @(negedge clk);
    ack_man = 1'b0;
  endtask

  task automatic expect_byte(input string t, input logic [7:0] b,
                             input bit fe, input bit ov);
    chk(valid_o === 1'b1, t, "valid_o", valid_o, 1);
    chk(data_o === b, t, "data_o", data_o, b);
    chk(frame_err_o === fe, t, "frame_err_o", frame_err_o, fe);
    chk(overrun_o === ov, t, "overrun_o", overrun_o, ov);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    tag = "R1";
    chk({valid_o, frame_err_o, overrun_o, data_o} === 11'd0, "R1", "reset outputs",
        {valid_o, frame_err_o, overrun_o, data_o}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // R3 basic frame, LSB first
    tag = "R3";
    send(8'hA5, 1, NOM, 0);
    expect_byte("R3", 8'hA5, 0, 0);
    // R8 valid held without ack, cleared by ack
    tag = "R8";
    repeat (50) @(negedge clk);
    chk(valid_o === 1'b1, "R8", "valid held", valid_o, 1);
    do_ack();
    chk(valid_o === 1'b0, "R8", "valid after ack", valid_o, 0);

    // R4 rate deviation both ways
    tag = "R4";
    send(8'h3C, 1, NOM - 2, 0);
    expect_byte("R4", 8'h3C, 0, 0);
    do_ack();
    send(8'hC3, 1, NOM + 2, 0);
    expect_byte("R4", 8'hC3, 0, 0);
    do_ack();
    repeat (100) @(negedge clk);

    // R2 glitch rejected
    tag = "R2";
    hold_line(1'b0, 20);
    hold_line(1'b1, 300);
    chk(valid_o === 1'b0, "R2", "no delivery after glitch", valid_o, 0);
    chk(data_o === 8'hC3, "R2", "data unchanged", data_o, 8'hC3);

    // R5 low stop bit, then no re-arm while line low
    tag = "R5";
    send(8'h5E, 1, NOM, 1);
    expect_byte("R5", 8'h5E, 1, 0);
    do_ack();
    hold_line(1'b0, 300);
    chk(valid_o === 1'b0, "R5", "no re-arm while low", valid_o, 0);
    hold_line(1'b1, 200);
    chk(valid_o === 1'b0, "R5", "idle after release", valid_o, 0);

    // R6 strict two stop bits
    tag = "R6";
    two_stop = 1'b1; tol = 1'b0;
    send(8'h5A, 2, NOM, 0);
    expect_byte("R6", 8'h5A, 0, 0);
    do_ack();
    send(8'h81, 1, NOM, 0);
    hold_line(1'b0, NOM + 100);
    expect_byte("R6", 8'h81, 1, 0);
    do_ack();
    hold_line(1'b1, 200);

    // R7 tolerant back-to-back, no ack: R9 overrun on second
    tag = "R7";
    tol = 1'b1;
    send(8'h11, 1, NOM, 0);
    expect_byte("R7", 8'h11, 0, 0);
    send(8'h22, 1, NOM, 0);
    tag = "R9";
    expect_byte("R9", 8'h22, 0, 1);
    do_ack();
    hold_line(1'b1, 100);

    // R10 flags rewritten; R9 same-cycle ack gives no overrun
    tag = "R10";
    two_stop = 1'b0; tol = 1'b0;
    send(8'h77, 1, NOM, 0);
    expect_byte("R10", 8'h77, 0, 0);
    ack_on_del = 1'b1;
    tag = "R9";
    send(8'h99, 1, NOM, 0);
    ack_on_del = 1'b0;
    expect_byte("R9", 8'h99, 0, 0);
    do_ack();
    chk(valid_o === 1'b0, "R8", "valid after final ack", valid_o, 0);
    hold_line(1'b1, 100);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule